// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

This block turns a 64-bit input address into an output address by fetching 64-bit descriptors from memory, one at a time, over a plain request/response read port. It first decides which of two translation regions owns the input address. That choice uses each region's size field and a per-region top-byte-ignore flag. It then works out the starting level from the region's granule and input size, and walks table descriptors down until a block or page descriptor ends the walk. A walk can also end on a fault.

A requester presents an address and an access type (read or write) while the walker is idle. The walker does the walk and presents the result: an output address, a mask, permissions and a fault code with the address of the descriptor that failed. The result stays on the outputs until the requester acknowledges it. The region configuration inputs must stay stable while a walk is in progress.

Top module: `twalk_top`

## Requirements
- R1: Bit 55 of the input address selects the top-byte-ignore flag: `cfg_tbi[1]` when bit 55 is 1, `cfg_tbi[0]` when it is 0. When the selected flag is set, input bits [63:56] take no part in region matching.
- R2: Region 0 matches when its size field is nonzero and the checked input bits [63:64-size] are all zero. Region 1 matches when its size field is nonzero and its checked bits are all one. Region 0 has priority. If neither matches, a region whose size field is zero takes the address, with region 0 tried first. If no region takes it, or the chosen region's bit in `cfg_off` is set, the result is a translation fault with fault address 0 and no memory read.
- R3: The granule code maps to a log2 size g: 0 gives 12, 1 gives 14, 2 and 3 give 16. The stride is g-3 and the input size is 64 minus the size field. The start level is 4 - (input size - 4)/stride, using integer division. A start level outside 0..3 gives a translation fault with no memory read.
- R4: The first table base is bits [47:0] of the region base with its low (input size - stride*(4 - start level)) bits cleared. Level L uses shift s = g + (3-L)*stride. Its descriptor is read at table base + 8 * ((input masked to input size) >> s, keeping stride bits).
- R5: A read that returns an error ends the walk with fault code 3 (walk abort). The fault address is the descriptor address.
- R6: A descriptor with bit 0 clear, or with bits [1:0] = 01 at level 3, gives fault code 1 (translation) with the descriptor address.
- R7: Bits [1:0] = 01 below level 3 (block) or 11 at level 3 (page) end the walk. The output address is descriptor bits [47:s] joined with input bits [s-1:0].
- R8: A leaf with bit 7 set is read-only. A write to it gives fault code 2 (permission), and a successful result has `res_perm` = 01. Otherwise `res_perm` = 11, where bit 0 is read and bit 1 is write. A table descriptor (bits [1:0] = 11 below level 3) with bit 62 set gives a permission fault on a write. Otherwise the walk continues one level down, at descriptor bits [47:g].
- R9: On success `res_mask` is 2^g - 1 and `res_fault` is 0. Any fault forces `res_perm` and `res_mask` to 0.
- R10: `req_ready` is high only when no walk is pending. The result stays valid and unchanged until `res_ack` is seen. Only one descriptor read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 64 | Input address |
| req_write | input | 1 | 1 = write access, 0 = read |
| cfg_size0 | input | 6 | Region 0 size field |
| cfg_size1 | input | 6 | Region 1 size field |
| cfg_gran0 | input | 2 | Region 0 granule code |
| cfg_gran1 | input | 2 | Region 1 granule code |
| cfg_base0 | input | 64 | Region 0 table base register |
| cfg_base1 | input | 64 | Region 1 table base register |
| cfg_tbi | input | 2 | Top-byte-ignore flags, index = input bit 55 |
| cfg_off | input | 2 | Per-region walk disable |
| mem_req_valid | output | 1 | Descriptor read pulse |
| mem_req_addr | output | PA_W | Descriptor address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Descriptor |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | Result present |
| res_ack | input | 1 | Result consumed |
| res_addr | output | PA_W | Output address |
| res_mask | output | PA_W | Granule offset mask |
| res_perm | output | 2 | Bit 0 read, bit 1 write |
| res_fault | output | 2 | 0 none, 1 translation, 2 permission, 3 walk abort |
| res_fault_addr | output | PA_W | Descriptor address of a failing level |

## Verification
The hardest cases to reach from the ports are the region-selection edges. These are the gap between the two regions, a zero-sized region that takes every unclaimed address, and the top-byte-ignore flag chosen by bit 55. Each one needs a particular combination of size fields, flags and upper input bits. The stimulus sets those configurations directly, including a 64-bit input size that starts the walk at level 0 of a 64 KB granule. It then builds descriptor chains in a behavioural memory whose read latency varies from one read to the next. Faults at given levels are produced by overwriting single entries of a chain, or by marking one descriptor address as erroring.

// File: rtl/twalk_pkg.sv
package twalk_pkg;
  localparam int VA_W   = 64;
  localparam int DESC_W = 64;
  localparam int TSZ_W  = 6;
  localparam int SHW    = 7;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TRANS = 2'd1,
    FLT_PERM  = 2'd2,
    FLT_ABORT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    DK_BAD   = 2'd0,
    DK_TABLE = 2'd1,
    DK_LEAF  = 2'd2
  } dkind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_ISSUE, ST_WAIT, ST_DONE
  } wstate_e;

  typedef struct packed {
    logic           ok;
    logic [2:0]     lvl;
    logic [SHW-1:0] base_bits;
  } start_t;

  // log2 of the granule size
  function automatic logic [4:0] gran_shift(input logic [1:0] code);
    case (code)
      2'd0:    gran_shift = 5'd12;
      2'd1:    gran_shift = 5'd14;
      default: gran_shift = 5'd16;
    endcase
  endfunction

  // ones in bits below n, all ones for n >= 64
  function automatic logic [VA_W-1:0] low_mask(input logic [SHW-1:0] n);
    low_mask = (n >= SHW'(VA_W)) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  // address bits resolved below a given level
  function automatic logic [SHW-1:0] level_shift(input logic [2:0] lvl, input logic [4:0] g);
    level_shift = SHW'(g) + SHW'(3'd3 - lvl) * SHW'(g - 5'd3);
  endfunction

  // starting level and base alignment from input size and granule
  function automatic start_t start_info(input logic [SHW-1:0] isz, input logic [4:0] g);
    logic [SHW-1:0] stride;
    logic [SHW-1:0] q;
    stride = SHW'(g) - 7'd3;
    q = (isz >= 7'd4) ? (isz - 7'd4) / stride : 7'd0;
    start_info.ok        = (q >= 7'd1) && (q <= 7'd4);
    start_info.lvl       = 3'(7'd4 - q);
    start_info.base_bits = isz - stride * q;
  endfunction
endpackage

// File: rtl/twalk_region_sel.sv
module twalk_region_sel
  import twalk_pkg::*;
(
  input  logic [VA_W-1:0]             va,
  input  logic [1:0][TSZ_W-1:0]       sizes,
  input  logic [1:0]                  tbi,
  output logic                        hit,
  output logic                        pick
);
  logic            tbi_on;
  logic [1:0]      claims;
  logic [1:0]      empty;

  assign tbi_on = va[VA_W-9] ? tbi[1] : tbi[0];

  for (genvar r = 0; r < 2; r++) begin : g_region
    logic [VA_W-1:0] chk;
    always_comb begin
      for (int i = 0; i < VA_W; i++) begin
        chk[i] = (i >= VA_W - int'(sizes[r])) && (i < (tbi_on ? VA_W - 8 : VA_W));
      end
    end
    assign empty[r] = (sizes[r] == '0);
    if (r == 0) begin : g_low
      assign claims[r] = !empty[r] && ((va & chk) == '0);
    end else begin : g_high
      assign claims[r] = !empty[r] && ((va & chk) == chk);
    end
  end

  always_comb begin
    hit  = 1'b1;
    pick = 1'b0;
    if (claims[0])      pick = 1'b0;
    else if (claims[1]) pick = 1'b1;
    else if (empty[0])  pick = 1'b0;
    else if (empty[1])  pick = 1'b1;
    else                hit  = 1'b0;
  end
endmodule

// File: rtl/twalk_desc_dec.sv
module twalk_desc_dec
  import twalk_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [2:0]        lvl,
  input  logic              is_write,
  input  logic [VA_W-1:0]   va,
  input  logic [SHW-1:0]    lshift,
  input  logic [4:0]        gshift,
  output dkind_e            kind,
  output logic              perm_fault,
  output logic [1:0]        leaf_perm,
  output logic [PA_W-1:0]   leaf_addr,
  output logic [PA_W-1:0]   next_base
);
  logic [VA_W-1:0] lm_level;
  logic [VA_W-1:0] lm_gran;
  logic            unused_hi;

  assign lm_level  = low_mask(lshift);
  assign lm_gran   = low_mask(SHW'(gshift));
  assign unused_hi = ^desc[DESC_W-1:PA_W];

  always_comb begin
    kind = DK_BAD;
    if (desc[0]) begin
      if (lvl == 3'd3) kind = desc[1] ? DK_LEAF : DK_BAD;
      else             kind = desc[1] ? DK_TABLE : DK_LEAF;
    end
  end

  always_comb begin
    case (kind)
      DK_LEAF:  perm_fault = is_write && desc[7];
      DK_TABLE: perm_fault = is_write && desc[62];
      default:  perm_fault = 1'b0;
    endcase
  end

  assign leaf_perm = {~desc[7], 1'b1};
  assign leaf_addr = (desc[PA_W-1:0] & ~lm_level[PA_W-1:0]) | (va[PA_W-1:0] & lm_level[PA_W-1:0]);
  assign next_base = desc[PA_W-1:0] & ~lm_gran[PA_W-1:0];
endmodule

// File: rtl/twalk_top.sv
module twalk_top
  import twalk_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_va,
  input  logic              req_write,
  input  logic [5:0]        cfg_size0,
  input  logic [5:0]        cfg_size1,
  input  logic [1:0]        cfg_gran0,
  input  logic [1:0]        cfg_gran1,
  input  logic [63:0]       cfg_base0,
  input  logic [63:0]       cfg_base1,
  input  logic [1:0]        cfg_tbi,
  input  logic [1:0]        cfg_off,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              res_valid,
  input  logic              res_ack,
  output logic [PA_W-1:0]   res_addr,
  output logic [PA_W-1:0]   res_mask,
  output logic [1:0]        res_perm,
  output logic [1:0]        res_fault,
  output logic [PA_W-1:0]   res_fault_addr
);
  wstate_e          state;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [2:0]       lvl_q;
  logic [4:0]       g_q;
  logic [SHW-1:0]   isz_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  daddr_q;
  fault_e           fault_q;

  // region choice for the latched address
  logic                  sel_hit;
  logic                  sel_pick;
  logic [1:0][TSZ_W-1:0] sizes;
  logic [TSZ_W-1:0]      size_sel;
  logic [4:0]            g_sel;
  logic [SHW-1:0]        isz_sel;
  logic [63:0]           base_sel;
  start_t                st_sel;
  logic [VA_W-1:0]       align_mask;
  logic                  unused_base;

  assign sizes    = {cfg_size1, cfg_size0};
  assign size_sel = sel_pick ? cfg_size1 : cfg_size0;
  assign g_sel    = gran_shift(sel_pick ? cfg_gran1 : cfg_gran0);
  assign isz_sel  = SHW'(VA_W) - SHW'(size_sel);
  assign base_sel = sel_pick ? cfg_base1 : cfg_base0;
  assign st_sel   = start_info(isz_sel, g_sel);
  assign align_mask  = low_mask(st_sel.base_bits);
  assign unused_base = ^{cfg_base0[63:PA_W], cfg_base1[63:PA_W]};

  twalk_region_sel u_sel (
    .va    (va_q),
    .sizes (sizes),
    .tbi   (cfg_tbi),
    .hit   (sel_hit),
    .pick  (sel_pick)
  );

  // descriptor address for the current level
  logic [SHW-1:0]   lshift;
  logic [VA_W-1:0]  idx;
  logic [PA_W-1:0]  desc_addr;

  assign lshift    = level_shift(lvl_q, g_q);
  assign idx       = ((va_q & low_mask(isz_q)) >> lshift) & low_mask(SHW'(g_q) - 7'd3);
  assign desc_addr = base_q + {idx[PA_W-4:0], 3'b000};

  dkind_e          kind;
  logic            perm_fault;
  logic [1:0]      leaf_perm;
  logic [PA_W-1:0] leaf_addr;
  logic [PA_W-1:0] next_base;
  logic [VA_W-1:0] gran_mask;

  assign gran_mask = low_mask(SHW'(g_q));

  twalk_desc_dec #(.PA_W(PA_W)) u_dec (
    .desc       (mem_rsp_data),
    .lvl        (lvl_q),
    .is_write   (wr_q),
    .va         (va_q),
    .lshift     (lshift),
    .gshift     (g_q),
    .kind       (kind),
    .perm_fault (perm_fault),
    .leaf_perm  (leaf_perm),
    .leaf_addr  (leaf_addr),
    .next_base  (next_base)
  );

  // named events for the checks
  logic ev_accept, ev_gap, ev_sel_fault, ev_rsp, ev_read_err, ev_step, ev_leaf_ok;
  assign ev_accept    = req_valid && req_ready;
  assign ev_gap       = (state == ST_SEL) && !sel_hit;
  assign ev_sel_fault = (state == ST_SEL) && (!sel_hit || cfg_off[sel_pick] || !st_sel.ok);
  assign ev_rsp       = (state == ST_WAIT) && mem_rsp_valid;
  assign ev_read_err  = ev_rsp && mem_rsp_err;
  assign ev_step      = ev_rsp && !mem_rsp_err && (kind == DK_TABLE) && !perm_fault;
  assign ev_leaf_ok   = ev_rsp && !mem_rsp_err && (kind == DK_LEAF) && !perm_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      va_q           <= '0;
      wr_q           <= 1'b0;
      lvl_q          <= '0;
      g_q            <= 5'd12;
      isz_q          <= '0;
      base_q         <= '0;
      daddr_q        <= '0;
      fault_q        <= FLT_NONE;
      res_addr       <= '0;
      res_mask       <= '0;
      res_perm       <= '0;
      res_fault_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_accept) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          state <= ST_SEL;
        end
        ST_SEL: begin
          if (ev_sel_fault) begin
            fault_q        <= FLT_TRANS;
            res_addr       <= '0;
            res_mask       <= '0;
            res_perm       <= '0;
            res_fault_addr <= '0;
            state          <= ST_DONE;
          end else begin
            g_q    <= g_sel;
            isz_q  <= isz_sel;
            lvl_q  <= st_sel.lvl;
            base_q <= base_sel[PA_W-1:0] & ~align_mask[PA_W-1:0];
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          daddr_q <= desc_addr;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (mem_rsp_valid) begin
          if (ev_step) begin
            base_q <= next_base;
            lvl_q  <= lvl_q + 3'd1;
            state  <= ST_ISSUE;
          end else begin
            state <= ST_DONE;
            if (ev_leaf_ok) begin
              fault_q        <= FLT_NONE;
              res_addr       <= leaf_addr;
              res_mask       <= gran_mask[PA_W-1:0];
              res_perm       <= leaf_perm;
              res_fault_addr <= '0;
            end else begin
              if (mem_rsp_err)          fault_q <= FLT_ABORT;
              else if (kind == DK_BAD)  fault_q <= FLT_TRANS;
              else                      fault_q <= FLT_PERM;
              res_addr       <= '0;
              res_mask       <= '0;
              res_perm       <= '0;
              res_fault_addr <= daddr_q;
            end
          end
        end
        ST_DONE: if (res_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign res_valid     = (state == ST_DONE);
  assign res_fault     = fault_q;
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_addr  = desc_addr;

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ack |=> res_valid && $stable(res_addr) && $stable(res_fault) && $stable(res_perm)); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready && !res_valid); // R10
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R10
  AST_GAP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gap |=> res_valid && res_fault == FLT_TRANS && !mem_req_valid); // R2
  AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R4
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> lvl_q <= 3'd3); // R3
  AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_err |=> res_valid && res_fault == FLT_ABORT && res_fault_addr == $past(mem_req_addr, 2)); // R5
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != FLT_NONE |-> res_perm == 2'b00 && res_mask == '0); // R9
  AST_OK_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == FLT_NONE |-> res_perm[0] && res_mask != '0); // R8
endmodule

// File: tb/twalk_top_tb.sv
module twalk_top_tb;
  localparam int PA_W = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [63:0]     req_va = '0;
  logic            req_write = 1'b0;
  logic [5:0]      cfg_size0 = 6'd25, cfg_size1 = 6'd25;
  logic [1:0]      cfg_gran0 = 2'd0, cfg_gran1 = 2'd2;
  logic [63:0]     cfg_base0 = 64'hFFFF_0000_1000_0000;
  logic [63:0]     cfg_base1 = 64'h0000_0000_2000_0000;
  logic [1:0]      cfg_tbi = 2'b10;
  logic [1:0]      cfg_off = 2'b00;
  logic            mem_req_valid;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            mem_rsp_err = 1'b0;
  logic            res_valid;
  logic            res_ack = 1'b0;
  logic [PA_W-1:0] res_addr, res_mask, res_fault_addr;
  logic [1:0]      res_perm, res_fault;

  twalk_top #(.PA_W(PA_W)) u_dut (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit busy = 1'b0;
  int rd_count = 0;
  int alloc = 0;
  logic [63:0] mem [logic [47:0]];
  bit          errset [logic [47:0]];
  logic [47:0] path [4];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // memory: one read at a time, latency 1..3 cycles
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err = 1'b0;
      if (mem_req_valid) begin
        logic [47:0] a;
        a = mem_req_addr;
        rd_count++;
        repeat (1 + rd_count % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = errset.exists(a);
        mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
      end
    end
  end

  // every cycle: ready follows the bench's own busy flag (R10)
  initial begin
    forever begin
      @(posedge clk); #3;
      if (rst_n) chk("R10", "ready vs idle", {63'd0, req_ready}, {63'd0, !busy});
    end
  end

  function automatic logic [63:0] lm(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [47:0] daddr(input logic [47:0] b, input logic [63:0] va, input int l, input int g, input int isz);
    int st, ls;
    logic [63:0] ix;
    st = g - 3;
    ls = g + (3 - l) * st;
    ix = ((va & lm(isz)) >> ls) & lm(st);
    return b + 48'(ix * 8);
  endfunction

  function automatic int gcode(input logic [1:0] c);
    return (c == 0) ? 12 : (c == 1) ? 14 : 16;
  endfunction

  // behavioural walk straight from the requirements
  task automatic ref_walk(input logic [63:0] va, input bit wr, output int flt, output logic [63:0] oa,
                          output logic [63:0] msk, output int perm, output logic [63:0] fa, output int nrd);
    bit tb_on, in0, in1, found;
    int top, r, g, st, isz, q, lvl, ls, sz0, sz1;
    logic [47:0] b, da;
    logic [63:0] d;
    flt = 1; oa = 0; msk = 0; perm = 0; fa = 0; nrd = 0;
    sz0 = cfg_size0; sz1 = cfg_size1;
    tb_on = va[55] ? cfg_tbi[1] : cfg_tbi[0];
    top = tb_on ? 56 : 64;
    in0 = sz0 != 0; in1 = sz1 != 0;
    for (int i = 0; i < 64; i++) begin
      if (i >= 64 - sz0 && i < top && va[i]) in0 = 0;
      if (i >= 64 - sz1 && i < top && !va[i]) in1 = 0;
    end
    found = 1;
    if (in0) r = 0; else if (in1) r = 1; else if (sz0 == 0) r = 0; else if (sz1 == 0) r = 1;
    else found = 0;
    if (!found || cfg_off[r]) return;
    g = gcode(r ? cfg_gran1 : cfg_gran0);
    st = g - 3;
    isz = 64 - (r ? sz1 : sz0);
    q = (isz >= 4) ? (isz - 4) / st : 0;
    lvl = 4 - q;
    if (lvl < 0 || lvl > 3) return;
    b = (r ? cfg_base1[47:0] : cfg_base0[47:0]) & ~(48'(lm(isz - st * q)));
    while (1) begin
      ls = g + (3 - lvl) * st;
      da = daddr(b, va, lvl, g, isz);
      nrd++;
      fa = {16'd0, da};
      if (errset.exists(da)) begin flt = 3; return; end
      d = mem.exists(da) ? mem[da] : 0;
      if (!d[0] || (lvl == 3 && d[1:0] == 2'b01)) begin flt = 1; return; end
      if (lvl == 3 || d[1:0] == 2'b01) begin
        if (wr && d[7]) begin flt = 2; return; end
        flt = 0; fa = 0;
        oa = ({16'd0, d[47:0]} & ~lm(ls)) | (va & lm(ls));
        msk = lm(g);
        perm = d[7] ? 1 : 3;
        return;
      end
      if (wr && d[62]) begin flt = 2; return; end
      b = d[47:0] & ~(48'(lm(g)));
      lvl++;
    end
  endtask

  task automatic chain(input logic [63:0] va, input logic [47:0] tbase, input int g, input int isz,
                       input int l0, input int leaf_l, input logic [63:0] leaf, input logic [63:0] tflags);
    logic [47:0] b, da, nb;
    b = tbase;
    for (int l = l0; l <= leaf_l; l++) begin
      da = daddr(b, va, l, g, isz);
      path[l] = da;
      if (l == leaf_l) mem[da] = leaf;
      else begin
        nb = 48'h4000_0000 + 48'(alloc) * 48'h1_0000;
        alloc++;
        mem[da] = {16'd0, nb} | 64'h3 | tflags;
        b = nb;
      end
    end
  endtask

  task automatic walk(input string req, input logic [63:0] va, input bit wr, input int hold);
    int ef, ep, enr;
    logic [63:0] eo, em, efa;
    ref_walk(va, wr, ef, eo, em, ep, efa, enr);
    @(negedge clk);
    req_va = va; req_write = wr; req_valid = 1'b1; busy = 1'b1; rd_count = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk(req, "fault", 64'(res_fault), 64'(ef));
    chk(req, "addr", 64'(res_addr), eo);
    chk(req, "mask", 64'(res_mask), em);
    chk(req, "perm", 64'(res_perm), 64'(ep));
    chk(req, "fault addr", 64'(res_fault_addr), efa);
    chk(req, "reads", 64'(rd_count), 64'(enr));
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R10", "held valid", 64'(res_valid), 64'd1);
      chk("R10", "held addr", 64'(res_addr), eo);
    end
    res_ack = 1'b1; busy = 1'b0;
    @(negedge clk);
    res_ack = 1'b0;
  endtask

  localparam logic [47:0] B0 = 48'h1000_0000;
  localparam logic [47:0] B1 = 48'h2000_0000;

  initial begin
    logic [63:0] va;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10", "reset ready", 64'(req_ready), 64'd1);
    chk("R10", "reset res_valid", 64'(res_valid), 64'd0);
    chk("R10", "reset mem_req", 64'(mem_req_valid), 64'd0);

    // 4 KB region 0, start level 1, page (R4 R7 R9)
    va = 64'h12_3456_7ABC;
    chain(va, B0, 12, 39, 1, 3, 64'h8_8888_8000 | 64'h3, 64'h0);
    walk("R7", va, 1'b1, 0);
    // read-only page: read ok, write faults (R8)
    va = 64'h03_0000_5123;
    chain(va, B0, 12, 39, 1, 3, 64'h5_5555_5000 | 64'h83, 64'h0);
    walk("R8", va, 1'b0, 3);
    walk("R8", va, 1'b1, 0);
    // level 2 and level 1 blocks (R7)
    va = 64'h05_4321_0FED;
    chain(va, B0, 12, 39, 1, 2, 64'h7_7760_0000 | 64'h1, 64'h0);
    walk("R7", va, 1'b1, 1);
    va = 64'h41_2345_6789;
    chain(va, B0, 12, 39, 1, 1, 64'h40_0000_0000 | 64'h1, 64'h0);
    walk("R7", va, 1'b0, 0);
    // table with write restriction (R8)
    va = 64'h22_1111_2222;
    chain(va, B0, 12, 39, 1, 3, 64'h3_0000_0000 | 64'h3, 64'h4000_0000_0000_0000);
    walk("R8", va, 1'b1, 0);
    walk("R8", va, 1'b0, 0);
    // invalid at level 2, reserved at level 3 (R6)
    va = 64'h33_0040_0000;
    chain(va, B0, 12, 39, 1, 2, 64'h0, 64'h0);
    walk("R6", va, 1'b0, 0);
    va = 64'h34_0080_1000;
    chain(va, B0, 12, 39, 1, 3, 64'h9_0000_0000 | 64'h1, 64'h0);
    walk("R6", va, 1'b0, 0);
    // read error on level 2 descriptor (R5)
    va = 64'h36_0123_4000;
    chain(va, B0, 12, 39, 1, 3, 64'h9_1000_0000 | 64'h3, 64'h0);
    errset[path[2]] = 1'b1;
    walk("R5", va, 1'b0, 0);
    // gap with top byte set, flag for bit55=0 off (R2 R1)
    walk("R2", 64'h5A00_0000_0000_1000, 1'b0, 0);
    // region 1, 64 KB granule, top byte ignored via bit 55 (R1 R3)
    va = 64'h3CFF_FF80_0123_4567;
    chain(va, B1, 16, 39, 2, 3, 64'h6_6666_0000 | 64'h3, 64'h0);
    walk("R1", va, 1'b1, 0);
    cfg_tbi = 2'b00;
    walk("R1", va, 1'b1, 0);
    cfg_tbi = 2'b01;
    walk("R1", 64'h5A00_0012_3456_7ABC, 1'b1, 0);
    // zero-size region 1 takes the rest, 64-bit input, level 0 (R2 R3)
    cfg_size1 = 6'd0;
    va = 64'h8000_1234_5678_9ABC;
    chain(va, B1, 16, 64, 0, 3, 64'h1_2345_0000 | 64'h3, 64'h0);
    walk("R2", va, 1'b0, 0);
    cfg_size1 = 6'd25;
    // disabled region (R2)
    cfg_off = 2'b01;
    walk("R2", 64'h12_3456_7ABC, 1'b0, 0);
    cfg_off = 2'b00;
    // start level out of range (R3)
    cfg_size0 = 6'd60;
    walk("R3", 64'h0000_0000_0000_0005, 1'b0, 0);
    // 16 KB granule, 48-bit input, four levels (R3 R4)
    cfg_size0 = 6'd16; cfg_gran0 = 2'd1;
    va = 64'h0000_9876_5432_1ABC;
    chain(va, B0, 14, 48, 0, 3, 64'h2_2222_4000 | 64'h3, 64'h0);
    walk("R3", va, 1'b1, 2);
    walk("R4", 64'h0000_1876_5432_1ABC, 1'b0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule